// File: doc/BRIEF.md
# Motor PWM Output Channel

This block drives one output of a motor bridge with pulse-width modulation. A frame counter advances once per clock. It runs from zero up to a programmable period minus one and pulses a wrap flag on the last count of each frame. A duty magnitude sets how many counts of each frame the output spends at its active level. A recirculation select sets which pin level counts as active. A two-bit delay code moves the start of the active window later within the frame by 0 to 3 counts. Bit 15 of the duty word is a sign. It decides which of two bridge sides (forward or reverse) has its output-enable raised. The other side is parked at the inactive level.

Settings are sampled only when a frame begins, so a change made in the middle of a frame takes effect at the next frame. The channel starts when it is enabled with a nonzero period. The channel does not stop at once when it is disabled or when its period is cleared. It finishes the current frame and releases both enables on the wrap. No delay is added to the release. The enables stay released until the channel is enabled again with a nonzero period. All control and status pins are plain levels. No stream handshake is involved.

Top module: `mpwm_chan`

## Requirements
- R1: After reset, both output-enables are 0, both pins are 1 (the inactive level for recirculation 0) and the wrap flag is 0.
- R2: When the channel is idle and sees enable = 1 with period P ≠ 0, both of the following hold from the next cycle. An enable is raised. The counter runs 0..P−1 repeatedly, with frame_wrap high exactly on count P−1.
- R3: For 0 < duty < P and delay code d, the selected pin is at the active level on counts d through d+duty−1 (limited to counts below P) and at the inactive level otherwise. The active level equals the recirculation select (0 = low, 1 = high).
- R4: A duty magnitude of 0 holds the selected pin at the inactive level for the whole frame: high for recirculation 0, low for recirculation 1.
- R5: A duty magnitude ≥ P holds the selected pin at the active level for the whole frame: low for recirculation 0, high for recirculation 1.
- R6: Delay codes 0, 1, 2 and 3 shift the active window start by 0, 1, 2 and 3 counts respectively.
- R7: Duty bit 15 selects the side. With 0, oe_fwd = 1 and pin_rev is held at the inactive level. With 1, oe_rev = 1 and pin_fwd is held at the inactive level. Duty bits 10..0 are the magnitude. Bits 14..11 have no effect on any output.
- R8: Period, duty, recirculation and delay are captured only on the cycle a frame begins (start from idle or wrap). A change at any other time leaves the outputs of the current frame unchanged.
- R9: If enable = 0 or period = 0 on a wrap cycle, both enables are 0 from the next cycle and both pins sit at the inactive level. They stay so until enable = 1 with a nonzero period is seen.
- R10: oe_fwd and oe_rev are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Channel enable |
| period | input | 11 | Frame length in counts, 0 stops the channel |
| duty | input | 16 | Bit 15 sign, bits 10..0 magnitude |
| recirc | input | 1 | Active level select: 0 low, 1 high |
| dly | input | 2 | Active window delay code, 0..3 counts |
| pin_fwd | output | 1 | Forward side pin level |
| pin_rev | output | 1 | Reverse side pin level |
| oe_fwd | output | 1 | Forward side output-enable |
| oe_rev | output | 1 | Reverse side output-enable |
| frame_wrap | output | 1 | High on the last count of a frame |

## Verification
The properties take it that every input holds a known value on each rising edge and that reset is asserted at power-up. They make no assumption about when settings change, because capture at frame start is itself under test. The stimulus changes inputs only on falling edges and never leaves them unknown. It deliberately changes period, duty and enable in the middle of frames, and it includes period 1, duty at and beyond the period, and all four delay codes.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int CNT_W  = 11;
  localparam int DUTY_W = 16;
  localparam int DLY_W  = 2;

  typedef struct packed {
    logic             sign;
    logic             recirc;
    logic [DLY_W-1:0] dly;
  } mode_t;
endpackage

// File: rtl/mpwm_frame_ctr.sv
module mpwm_frame_ctr #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] per_l,
  output logic          run,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign wrap = run_q && (cnt_q == per_l - CW'(1));
  assign run  = run_q;
  assign cnt  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q || wrap) begin
      run_q <= go;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/mpwm_cfg_hold.sv
module mpwm_cfg_hold #(
  parameter int CW = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CW-1:0]   per_i,
  input  logic [CW-1:0]   mag_i,
  input  mpwm_pkg::mode_t mode_i,
  output logic [CW-1:0]   per_q,
  output logic [CW-1:0]   mag_q,
  output mpwm_pkg::mode_t mode_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      mag_q  <= '0;
      mode_q <= '0;
    end else if (load) begin
      per_q  <= per_i;
      mag_q  <= mag_i;
      mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/mpwm_level.sv
module mpwm_level #(
  parameter int CW = 11
) (
  input  logic            run,
  input  logic [CW-1:0]   cnt,
  input  logic [CW-1:0]   per,
  input  logic [CW-1:0]   mag,
  input  mpwm_pkg::mode_t mode,
  output logic            pin_fwd,
  output logic            pin_rev,
  output logic            oe_fwd,
  output logic            oe_rev
);
  localparam int XW = CW + 1;

  logic [XW-1:0] win_lo, win_hi, cnt_x;
  logic          in_win, full_on, active, lvl, idle_lvl;
  logic [1:0]    side_on, side_pin;

  always_comb begin
    cnt_x    = {1'b0, cnt};
    win_lo   = XW'(mode.dly);
    win_hi   = {1'b0, mag} + win_lo;
    in_win   = (cnt_x >= win_lo) && (cnt_x < win_hi);
    full_on  = (mag >= per);
    active   = (mag != '0) && (full_on || in_win);
    idle_lvl = ~mode.recirc;
    lvl      = active ? mode.recirc : idle_lvl;
  end

  // side 0 = forward (sign 0), side 1 = reverse (sign 1)
  for (genvar s = 0; s < 2; s++) begin : g_side
    assign side_on[s]  = run && (mode.sign == 1'(s));
    assign side_pin[s] = side_on[s] ? lvl : idle_lvl;
  end

  assign oe_fwd  = side_on[0];
  assign oe_rev  = side_on[1];
  assign pin_fwd = side_pin[0];
  assign pin_rev = side_pin[1];
endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan #(
  parameter int CW = mpwm_pkg::CNT_W,
  parameter int DW = mpwm_pkg::DUTY_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic [DW-1:0] duty,
  input  logic          recirc,
  input  logic [1:0]    dly,
  output logic          pin_fwd,
  output logic          pin_rev,
  output logic          oe_fwd,
  output logic          oe_rev,
  output logic          frame_wrap
);
  localparam int SIGN_BIT = DW - 1;

  logic            go, load, run;
  logic [CW-1:0]   cnt, per_l, mag_l;
  mpwm_pkg::mode_t mode_in, mode_l;
  logic            unused_hi;

  assign unused_hi = ^duty[SIGN_BIT-1:CW];

  assign go      = en && (period != '0);
  assign load    = go && (!run || frame_wrap);
  assign mode_in = '{sign: duty[SIGN_BIT], recirc: recirc, dly: dly};

  mpwm_frame_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .go(go), .per_l(per_l),
    .run(run), .cnt(cnt), .wrap(frame_wrap)
  );

  mpwm_cfg_hold #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(load),
    .per_i(period), .mag_i(duty[CW-1:0]), .mode_i(mode_in),
    .per_q(per_l), .mag_q(mag_l), .mode_q(mode_l)
  );

  mpwm_level #(.CW(CW)) u_lvl (
    .run(run), .cnt(cnt), .per(per_l), .mag(mag_l), .mode(mode_l),
    .pin_fwd(pin_fwd), .pin_rev(pin_rev), .oe_fwd(oe_fwd), .oe_rev(oe_rev)
  );
endmodule

// File: rtl/mpwm_chan_chk.sv
module mpwm_chan_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [CW-1:0] period,
  input logic          pin_fwd,
  input logic          pin_rev,
  input logic          oe_fwd,
  input logic          oe_rev,
  input logic          frame_wrap,
  input logic          rec_l,
  input logic [CW-1:0] mag_l
);
  logic oe_any, go_in;
  assign oe_any = oe_fwd || oe_rev;
  assign go_in  = en && (period != '0);

  // R10
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({oe_fwd, oe_rev}));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_wrap && !go_in) |=> !oe_any);

  // R9
  stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_any && !go_in) |=> !oe_any);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_any && go_in) |=> oe_any);

  // R7
  park_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_fwd |-> (pin_rev == !rec_l));

  // R7
  park_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_rev |-> (pin_fwd == !rec_l));

  // R4
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_fwd && mag_l == '0) |-> (pin_fwd == !rec_l));
endmodule

bind mpwm_chan mpwm_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .period(period),
  .pin_fwd(pin_fwd), .pin_rev(pin_rev), .oe_fwd(oe_fwd), .oe_rev(oe_rev),
  .frame_wrap(frame_wrap), .rec_l(mode_l.recirc), .mag_l(mag_l)
);

// File: tb/tb_mpwm_chan.sv
module tb_mpwm_chan;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [10:0] period = '0;
  logic [15:0] duty = '0;
  logic        recirc = 1'b0;
  logic [1:0]  dly = '0;
  logic        pin_fwd, pin_rev, oe_fwd, oe_rev, frame_wrap;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference state
  bit m_run = 0;
  int m_cnt = 0, m_per = 0, m_mag = 0, m_dly = 0;
  bit m_sign = 0, m_rec = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpwm_chan dut (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty(duty),
    .recirc(recirc), .dly(dly), .pin_fwd(pin_fwd), .pin_rev(pin_rev),
    .oe_fwd(oe_fwd), .oe_rev(oe_rev), .frame_wrap(frame_wrap)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_per = 0; m_mag = 0; m_dly = 0; m_sign = 0; m_rec = 0;
    end else begin
      bit go_e, last;
      go_e = en && (period != 0);
      last = m_run && (m_cnt == m_per - 1);
      if (!m_run || last) begin
        if (go_e) begin
          m_per = int'(period); m_mag = int'(duty[10:0]); m_sign = duty[15];
          m_rec = recirc; m_dly = int'(dly);
        end
        m_run = go_e;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic check1(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", cur_req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit act, lvl, e_fwd, e_rev, e_wrap;
      e_wrap = m_run && (m_cnt == m_per - 1);
      act = (m_mag != 0) && ((m_mag >= m_per) ||
            (m_cnt >= m_dly && m_cnt < m_dly + m_mag));
      lvl = act ? m_rec : !m_rec;
      e_fwd = (m_run && !m_sign) ? lvl : !m_rec;
      e_rev = (m_run && m_sign) ? lvl : !m_rec;
      check1("frame_wrap", int'(frame_wrap), int'(e_wrap));
      check1("oe_fwd", int'(oe_fwd), int'(m_run && !m_sign));
      check1("oe_rev", int'(oe_rev), int'(m_run && m_sign));
      check1("pin_fwd", int'(pin_fwd), int'(e_fwd));
      check1("pin_rev", int'(pin_rev), int'(e_rev));
      n_cmp++;
      if (oe_fwd && oe_rev) begin
        n_bad++;
        $display("FAIL R10 both enables at cycle %0d: actual 1 expected 0", cyc);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      n_bad++;
      $display("FAIL watchdog at cycle %0d: actual running expected finished", cyc);
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(bit e, int p, logic [15:0] d, bit r, int dl);
    en = e; period = 11'(p); duty = d; recirc = r; dly = 2'(dl);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    cur_req = "R1";
    step(4);

    cur_req = "R2";
    cfg(1, 5, 16'd2, 0, 0); step(22);
    cfg(1, 1, 16'd0, 0, 0); step(6);

    cur_req = "R3";
    cfg(1, 7, 16'd3, 1, 0); step(30);
    cfg(1, 9, 16'd5, 0, 0); step(30);

    cur_req = "R6";
    for (int d = 0; d < 4; d++) begin
      cfg(1, 8, 16'd3, d[0], d); step(24);
    end
    cfg(1, 8, 16'd6, 0, 3); step(24);

    cur_req = "R4";
    cfg(1, 6, 16'd0, 0, 2); step(18);
    cfg(1, 6, 16'd0, 1, 0); step(18);

    cur_req = "R5";
    cfg(1, 6, 16'd6, 0, 1); step(18);
    cfg(1, 6, 16'd40, 1, 3); step(18);

    cur_req = "R7";
    cfg(1, 7, 16'h8003, 0, 0); step(21);
    cfg(1, 7, 16'h7803, 0, 0); step(21);
    cfg(1, 7, 16'hF803, 1, 1); step(21);

    cur_req = "R8";
    cfg(1, 10, 16'd4, 0, 0); step(13);
    for (int i = 0; i < 8; i++) begin
      cfg(1, 10 + i % 3, 16'(i + 1), i[0], i % 4); step(1);
    end
    step(20);

    cur_req = "R9";
    cfg(1, 9, 16'd3, 0, 0); step(14);
    en = 1'b0; step(20);
    en = 1'b1; step(22);
    period = '0; step(20);
    cfg(1, 5, 16'h8002, 1, 1); step(15);

    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        logic [15:0] w;
        w = 16'($urandom);
        w[10:0] = 11'($urandom_range(0, 14));
        cfg($urandom_range(0, 7) != 0, int'($urandom_range(0, 12)), w,
            1'($urandom), int'($urandom_range(0, 3)));
      end
      step(1);
    end

    finish_run();
  end
endmodule